// File: doc/BRIEF.md
# Universal Counter Measurement Sequencer

This block runs the measurement cycle of a multi-mode counter. It owns two counters: a BCD main counter whose value is shown to the user, and a decade reference counter that decides how long the main counter is allowed to count. The operating mode decides what each counter counts. In frequency mode the main counter counts input A against a fixed gate. In period mode it counts the timebase over a number of A cycles. In ratio mode it counts A over a number of B cycles. In time-interval mode it counts the timebase from an A fall to a B fall. In unit mode it counts A without stopping. In self-test mode it counts the timebase over the frequency gate. The range code sets the reference count to 1, 10, 100 or 1000.

When a window closes, the main count is copied into a display latch and a one-cycle strobe is raised. A fixed gap of gate ticks then passes before the next window opens. The gate tick is made from a timebase enable by a decade prescaler. The prescaler divides by `BASE_DIV*10`, or by `BASE_DIV` when the fine-timebase option is set, so the gate rate is the same for both crystal choices. A simulation can use a small `BASE_DIV`. The inputs `sig_a` and `sig_b` are levels that have already been synchronised to `clk`. The block acts only on their high-to-low transitions.

Top module: `ucnt_seq_top`

## Requirements
- R1: Frequency mode (mode code 0; codes 6 and 7 act the same) counts falls of `sig_a` while the window is open. The window opens on one gate tick and closes on the 10^range-th gate tick after it. One gate tick occurs every `BASE_DIV*10` timebase enables.
- R2: With `tb_1mhz` high, a gate tick occurs every `BASE_DIV` timebase enables instead.
- R3: Period mode (code 1) opens the window on a fall of `sig_a`. It counts timebase enables up to and including the 10^range-th later fall of `sig_a`.
- R4: Ratio mode (code 2) opens the window on a fall of `sig_b`. It counts falls of `sig_a` until the 10^range-th later fall of `sig_b`.
- R5: Time-interval mode (code 3) starts a window only after a fall of A and then a fall of B have been seen. A lone B fall does nothing. In each interval, counting starts the cycle after an A fall and includes the cycle of the closing B fall. The result is stored after 10^range intervals.
- R6: Unit mode (code 4) counts every `sig_a` fall. The display follows the count one cycle later. There is no store strobe, and a range change does not clear the count.
- R7: Self-test mode (code 5) counts timebase enables over the frequency window.
- R8: At window close, `disp_bcd` and `ovf_flag` take the count and `store_stb` is high for exactly one cycle. `meas_busy` then stays low for `GAP_TICKS` gate ticks, plus the tick that reopens the window.
- R9: A change of mode, or a change of range outside unit mode, ends the running window without a strobe and without changing the display. The next window is armed at once.
- R10: Outside unit mode, a high `hold` stops the window, clears the count and keeps the display. After `hold` falls, a new window is armed.
- R11: In unit mode, a high `hold` freezes only the display. Counting goes on, and the display catches up once `hold` is low.
- R12: A reset, or a high `clr_meas`, zeroes the display and `ovf_flag` and ends any window (`meas_busy` low).
- R13: A carry out of the top decade sets a sticky overflow. The overflow is stored with the result, so the next stored result without a carry shows `ovf_flag` low. Each 4-bit field of `disp_bcd` holds one BCD digit, with digit 0 in bits 3:0.
- R14: Rising edges of `sig_a` and `sig_b` are never counted or used as events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_meas | input | 1 | Functional clear of count, display and window |
| hold | input | 1 | Hold request |
| tb_tick | input | 1 | Timebase enable, one cycle per timebase period |
| tb_1mhz | input | 1 | Fine-timebase option (prescale by BASE_DIV) |
| sig_a | input | 1 | Synchronised input A level |
| sig_b | input | 1 | Synchronised input B level |
| mode_sel | input | 3 | Measurement mode code |
| range_sel | input | $clog2(RANGES) | Range code, reference count 10^range |
| disp_bcd | output | 4*DIGITS | Latched BCD result |
| store_stb | output | 1 | One-cycle strobe when a result is latched |
| ovf_flag | output | 1 | Latched overflow |
| meas_busy | output | 1 | Window open |

## Verification
Frequency and ratio runs feed a known burst of A pulses into a single window. The stored value shows whether rising edges, or events outside the window, leak into the count. Period and time-interval runs use a steady timebase with A and B edges placed to the cycle, so an off-by-one at the window's opening or closing edge changes the result. Self-test runs at two ranges with both prescale settings separate the two divide ratios, and they drive the two-digit counter past its carry to expose overflow. Unit-mode pulse trains with hold and range changes, and window aborts by hold and by range change, show which controls clear the count and which only freeze the display.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

   typedef enum logic [2:0] {
      M_FREQ   = 3'd0,
      M_PERIOD = 3'd1,
      M_RATIO  = 3'd2,
      M_TINT   = 3'd3,
      M_UNIT   = 3'd4,
      M_OSC    = 3'd5
   } meas_mode_t;

   typedef enum logic [1:0] {
      ST_ARM   = 2'd0,
      ST_RUN   = 2'd1,
      ST_STORE = 2'd2,
      ST_GAP   = 2'd3
   } win_state_t;

   function automatic int unsigned pow10(input int unsigned e);
      int unsigned r;
      r = 1;
      for (int unsigned i = 0; i < e; i++) r = r * 10;
      return r;
   endfunction

   function automatic meas_mode_t decode_mode(input logic [2:0] code);
      case (code)
         3'd1:    return M_PERIOD;
         3'd2:    return M_RATIO;
         3'd3:    return M_TINT;
         3'd4:    return M_UNIT;
         3'd5:    return M_OSC;
         default: return M_FREQ;
      endcase
   endfunction

endpackage

// File: rtl/ucnt_prescale.sv
module ucnt_prescale #(
   parameter int unsigned BASE_DIV = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tb_tick,
   input  logic fine_sel,
   output logic gate_tick
);
   localparam int unsigned HI_DIV = BASE_DIV * 10;
   localparam int unsigned CW     = $clog2(HI_DIV);

   generate
      if (BASE_DIV < 2) begin : g_bad_div
         $error("ucnt_prescale: BASE_DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim = fine_sel ? CW'(BASE_DIV - 1) : CW'(HI_DIV - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         gate_tick <= 1'b0;
      end else begin
         gate_tick <= 1'b0;
         if (tb_tick) begin
            if (cnt >= lim) begin
               cnt       <= '0;
               gate_tick <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R2: gate ticks are isolated single-cycle pulses
   a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      gate_tick |=> !gate_tick);

endmodule

// File: rtl/ucnt_bcd_chain.sv
module ucnt_bcd_chain #(
   parameter int unsigned DIGITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                inc,
   output logic [4*DIGITS-1:0] value,
   output logic                ovf
);
   generate
      if (DIGITS < 1) begin : g_bad_digits
         $error("ucnt_bcd_chain: DIGITS must be at least 1");
      end
   endgenerate

   logic [DIGITS:0] cy;
   assign cy[0] = inc;

   generate
      for (genvar g = 0; g < DIGITS; g++) begin : g_dec
         logic [3:0] d;
         assign cy[g+1] = cy[g] & (d == 4'd9);
         assign value[4*g +: 4] = d;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     d <= '0;
            else if (clr)   d <= '0;
            else if (cy[g]) d <= (d == 4'd9) ? 4'd0 : d + 4'd1;
         end

         // R13: every stored field stays a legal BCD digit
         a_r13_digit_bcd: assert property (@(posedge clk) disable iff (!rst_n)
            d <= 4'd9);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ovf <= 1'b0;
      else if (clr)        ovf <= 1'b0;
      else if (cy[DIGITS]) ovf <= 1'b1;
   end

   // R13: overflow is sticky until the count is cleared
   a_r13_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);

endmodule

// File: rtl/ucnt_ref_div.sv
module ucnt_ref_div
   import ucnt_pkg::*;
#(
   parameter int unsigned RANGES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      ev,
   input  logic [$clog2(RANGES)-1:0] range_idx,
   output logic                      done
);
   localparam int unsigned MAXT = pow10(RANGES - 1);
   localparam int unsigned CW   = (MAXT > 1) ? $clog2(MAXT) : 1;

   logic [CW-1:0] term_tab [RANGES];
   logic [CW-1:0] cnt;
   logic [CW-1:0] term;

   generate
      for (genvar g = 0; g < RANGES; g++) begin : g_term
         assign term_tab[g] = CW'(pow10(g) - 1);
      end
   endgenerate

   assign term = term_tab[range_idx];
   assign done = ev && (cnt == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (ev)  cnt <= done ? '0 : cnt + 1'b1;
   end

   // R1: the reference count never passes the largest terminal value
   a_r1_ref_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= term_tab[RANGES-1]);

endmodule

// File: rtl/ucnt_seq_top.sv
module ucnt_seq_top
   import ucnt_pkg::*;
#(
   parameter int unsigned DIGITS    = 8,
   parameter int unsigned RANGES    = 4,
   parameter int unsigned BASE_DIV  = 10000,
   parameter int unsigned GAP_TICKS = 20
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_meas,
   input  logic                      hold,
   input  logic                      tb_tick,
   input  logic                      tb_1mhz,
   input  logic                      sig_a,
   input  logic                      sig_b,
   input  logic [2:0]                mode_sel,
   input  logic [$clog2(RANGES)-1:0] range_sel,
   output logic [4*DIGITS-1:0]       disp_bcd,
   output logic                      store_stb,
   output logic                      ovf_flag,
   output logic                      meas_busy
);
   localparam int unsigned RW = $clog2(RANGES);
   localparam int unsigned GW = $clog2(GAP_TICKS + 1);

   generate
      if (RANGES < 2) begin : g_bad_ranges
         $error("ucnt_seq_top: RANGES must be at least 2");
      end
      if (GAP_TICKS < 1) begin : g_bad_gap
         $error("ucnt_seq_top: GAP_TICKS must be at least 1");
      end
   endgenerate

   // edge detection on the synchronised inputs
   logic a_q, b_q;
   logic fall_a, fall_b;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= 1'b0;
         b_q <= 1'b0;
      end else begin
         a_q <= sig_a;
         b_q <= sig_b;
      end
   end
   assign fall_a = a_q & ~sig_a;
   assign fall_b = b_q & ~sig_b;

   // configuration tracking
   meas_mode_t md;
   logic       unit_m;
   logic [2:0] mode_q;
   logic [RW-1:0] range_q;
   logic [RW-1:0] range_idx;
   logic       chg;

   assign md     = decode_mode(mode_sel);
   assign unit_m = (md == M_UNIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         range_q <= '0;
      end else begin
         mode_q  <= mode_sel;
         range_q <= range_sel;
      end
   end

   assign chg = (decode_mode(mode_q) != md) || ((range_q != range_sel) && !unit_m);

   generate
      if ((2 ** RW) != RANGES) begin : g_clamp
         assign range_idx = (range_sel > RW'(RANGES - 1)) ? RW'(RANGES - 1) : range_sel;
      end else begin : g_direct
         assign range_idx = range_sel;
      end
   endgenerate

   // gate tick
   logic gate_tick;
   ucnt_prescale #(.BASE_DIV(BASE_DIV)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .tb_tick   (tb_tick),
      .fine_sel  (tb_1mhz),
      .gate_tick (gate_tick)
   );

   // window state
   win_state_t state;
   logic       primed_a;
   logic       open_q;
   logic [GW-1:0] gap_cnt;

   logic start_ev, ref_ev, main_ev;
   always_comb begin
      start_ev = 1'b0;
      ref_ev   = 1'b0;
      main_ev  = 1'b0;
      case (md)
         M_FREQ: begin
            start_ev = gate_tick;
            ref_ev   = gate_tick;
            main_ev  = fall_a;
         end
         M_OSC: begin
            start_ev = gate_tick;
            ref_ev   = gate_tick;
            main_ev  = tb_tick;
         end
         M_PERIOD: begin
            start_ev = fall_a;
            ref_ev   = fall_a;
            main_ev  = tb_tick;
         end
         M_RATIO: begin
            start_ev = fall_b;
            ref_ev   = fall_b;
            main_ev  = fall_a;
         end
         M_TINT: begin
            start_ev = fall_b & primed_a;
            ref_ev   = fall_b & open_q;
            main_ev  = tb_tick & open_q;
         end
         default: begin
            main_ev  = fall_a;
         end
      endcase
   end

   logic abort;
   logic win_done;
   logic ref_clr;
   assign abort   = clr_meas | chg | (hold & ~unit_m);
   assign ref_clr = abort | (state != ST_RUN);

   ucnt_ref_div #(.RANGES(RANGES)) u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ref_clr),
      .ev        ((state == ST_RUN) & ref_ev),
      .range_idx (range_idx),
      .done      (win_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_ARM;
         primed_a <= 1'b0;
         open_q   <= 1'b0;
         gap_cnt  <= '0;
      end else if (abort) begin
         state    <= ST_ARM;
         primed_a <= 1'b0;
         open_q   <= 1'b0;
         gap_cnt  <= '0;
      end else begin
         case (state)
            ST_ARM: begin
               if ((md == M_TINT) && fall_a) primed_a <= 1'b1;
               if (!unit_m && start_ev) begin
                  state  <= ST_RUN;
                  open_q <= 1'b0;
               end
            end
            ST_RUN: begin
               if (fall_b && open_q)             open_q <= 1'b0;
               else if (fall_a && md == M_TINT)  open_q <= 1'b1;
               if (win_done) state <= ST_STORE;
            end
            ST_STORE: begin
               state   <= ST_GAP;
               gap_cnt <= '0;
               open_q  <= 1'b0;
            end
            default: begin
               if (gate_tick) begin
                  if (gap_cnt == GW'(GAP_TICKS - 1)) begin
                     state    <= ST_ARM;
                     primed_a <= 1'b0;
                  end else begin
                     gap_cnt <= gap_cnt + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   // main counter
   logic [4*DIGITS-1:0] main_val;
   logic                main_ovf;
   logic                main_clr;
   logic                main_inc;

   assign main_clr = clr_meas | chg |
                     (~unit_m & (hold | (state == ST_ARM) | (state == ST_GAP)));
   assign main_inc = unit_m ? fall_a : ((state == ST_RUN) & main_ev);

   ucnt_bcd_chain #(.DIGITS(DIGITS)) u_main (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (main_clr),
      .inc   (main_inc),
      .value (main_val),
      .ovf   (main_ovf)
   );

   // display latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_bcd  <= '0;
         ovf_flag  <= 1'b0;
         store_stb <= 1'b0;
      end else if (clr_meas) begin
         disp_bcd  <= '0;
         ovf_flag  <= 1'b0;
         store_stb <= 1'b0;
      end else begin
         store_stb <= 1'b0;
         if (unit_m) begin
            if (!hold && !chg) begin
               disp_bcd <= main_val;
               ovf_flag <= main_ovf;
            end
         end else if ((state == ST_STORE) && !abort) begin
            disp_bcd  <= main_val;
            ovf_flag  <= main_ovf;
            store_stb <= 1'b1;
         end
      end
   end

   assign meas_busy = (state == ST_RUN);

   // R8: strobe lasts one cycle
   a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      store_stb |=> !store_stb);

   // R6: unit mode never strobes
   a_r6_unit_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      unit_m |=> !store_stb);

   // R9: an abort never latches a result
   a_r9_abort_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (chg && !unit_m && !clr_meas) |=> (!store_stb && $stable(disp_bcd)));

   // R10: hold outside unit mode keeps the display and closes the window
   a_r10_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !unit_m && !clr_meas) |=> ($stable(disp_bcd) && !meas_busy));

   // R12: clear empties display and window
   a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_meas |=> ((disp_bcd == '0) && !ovf_flag && !meas_busy));

   // R5: no time-interval window opens before priming
   a_r5_needs_prime: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_ARM) && (md == M_TINT) && !primed_a) |=> !meas_busy);

endmodule

// File: tb/sim_ucnt_seq_top.sv
module sim_ucnt_seq_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr_meas = 1'b0;
   logic hold = 1'b0;
   logic tb_tick = 1'b1;
   logic tb_1mhz = 1'b0;
   logic sig_a = 1'b1;
   logic sig_b = 1'b1;
   logic [2:0] mode_sel = 3'd0;
   logic [1:0] range_sel = 2'd0;
   logic [7:0] disp;
   logic store_stb, ovf, busy;

   int checks = 0;
   int fails = 0;
   int store_cnt = 0;
   logic [7:0] st_disp = '0;
   logic st_ovf = 1'b0;

   always #5 clk = ~clk;

   ucnt_seq_top #(.DIGITS(2), .RANGES(4), .BASE_DIV(4), .GAP_TICKS(2)) u0 (
      .clk(clk), .rst_n(rst_n), .clr_meas(clr_meas), .hold(hold),
      .tb_tick(tb_tick), .tb_1mhz(tb_1mhz), .sig_a(sig_a), .sig_b(sig_b),
      .mode_sel(mode_sel), .range_sel(range_sel), .disp_bcd(disp),
      .store_stb(store_stb), .ovf_flag(ovf), .meas_busy(busy)
   );

   always @(negedge clk) begin
      if (store_stb) begin
         store_cnt = store_cnt + 1;
         st_disp = disp;
         st_ovf = ovf;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_busy(input logic lvl);
      int n = 0;
      while (busy !== lvl && n < 3000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic wait_store(input int base);
      int n = 0;
      while (store_cnt == base && n < 3000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic pulse_a(input int lo, input int hi);
      @(negedge clk) sig_a = 1'b0;
      repeat (lo) @(negedge clk);
      sig_a = 1'b1;
      repeat (hi - 1) @(negedge clk);
   endtask

   task automatic pulse_b(input int lo, input int hi);
      @(negedge clk) sig_b = 1'b0;
      repeat (lo) @(negedge clk);
      sig_b = 1'b1;
      repeat (hi - 1) @(negedge clk);
   endtask

   task automatic set_cfg(input int m, input int r, input logic fine);
      @(negedge clk);
      mode_sel = 3'(m);
      range_sel = 2'(r);
      tb_1mhz = fine;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R12 reset disp", disp, 0);
      chk("R12 reset ovf", ovf, 0);
      chk("R12 reset busy", busy, 0);
      chk("R8 reset strobe", store_stb, 0);
   endtask

   task automatic t_freq();
      int base;
      int n = 0;
      set_cfg(0, 0, 1'b0);
      wait_busy(1'b0);
      wait_busy(1'b1);
      base = store_cnt;
      repeat (7) pulse_a(1, 2);
      wait_store(base);
      chk("R1 freq count", st_disp, 8'h07);
      chk("R1 freq ovf", st_ovf, 0);
      @(negedge clk);
      chk("R8 strobe one cycle", store_stb, 0);
      while (busy !== 1'b1 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk("R8 gap length", (n >= 75 && n <= 130) ? 1 : 0, 1);
   endtask

   task automatic t_osc();
      int base;
      set_cfg(5, 0, 1'b0);
      wait_busy(1'b0); wait_busy(1'b1);
      base = store_cnt; wait_store(base);
      chk("R7 self-test coarse", st_disp, 8'h40);
      set_cfg(5, 0, 1'b1);
      wait_busy(1'b0); wait_busy(1'b1);
      base = store_cnt; wait_store(base);
      chk("R2 fine prescale", st_disp, 8'h04);
      set_cfg(5, 1, 1'b0);
      wait_busy(1'b0); wait_busy(1'b1);
      base = store_cnt; wait_store(base);
      chk("R13 wrapped digits", st_disp, 8'h00);
      chk("R13 overflow latched", st_ovf, 1);
      set_cfg(5, 0, 1'b0);
      wait_busy(1'b0); wait_busy(1'b1);
      base = store_cnt; wait_store(base);
      chk("R13 overflow cleared", st_ovf, 0);
      chk("R7 self-test repeat", st_disp, 8'h40);
   endtask

   task automatic t_period();
      int base;
      set_cfg(1, 1, 1'b0);
      base = store_cnt;
      for (int i = 0; i < 40 && store_cnt == base; i++) pulse_a(3, 3);
      wait_store(base);
      chk("R3 period ten cycles", st_disp, 8'h60);
   endtask

   task automatic t_ratio();
      int base;
      set_cfg(2, 0, 1'b0);
      base = store_cnt;
      pulse_b(1, 2);
      repeat (5) pulse_a(1, 2);
      pulse_b(1, 2);
      wait_store(base);
      chk("R4 ratio count", st_disp, 8'h05);
   endtask

   task automatic t_tint();
      int base;
      set_cfg(3, 0, 1'b0);
      pulse_b(1, 2);
      repeat (3) @(negedge clk);
      chk("R5 lone B no start", busy, 0);
      pulse_a(1, 2);
      pulse_b(1, 2);
      @(negedge clk);
      chk("R5 primed start", busy, 1);
      base = store_cnt;
      @(negedge clk) sig_a = 1'b0;
      @(negedge clk) sig_a = 1'b1;
      repeat (8) @(negedge clk);
      sig_b = 1'b0;
      @(negedge clk) sig_b = 1'b1;
      wait_store(base);
      chk("R5 interval cycles", st_disp, 8'h09);
   endtask

   task automatic t_unit();
      int base;
      set_cfg(4, 0, 1'b0);
      base = store_cnt;
      repeat (5) pulse_a(1, 2);
      repeat (3) @(negedge clk);
      chk("R14 falls only", disp, 8'h05);
      @(negedge clk) range_sel = 2'd2;
      repeat (2) pulse_a(1, 2);
      repeat (3) @(negedge clk);
      chk("R6 range change kept count", disp, 8'h07);
      @(negedge clk) hold = 1'b1;
      repeat (3) pulse_a(1, 2);
      repeat (3) @(negedge clk);
      chk("R11 display frozen", disp, 8'h07);
      @(negedge clk) hold = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 counting continued", disp, 8'h10);
      chk("R6 no strobe", store_cnt, base);
   endtask

   task automatic t_hold();
      int base;
      logic [7:0] d0;
      set_cfg(0, 0, 1'b0);
      wait_busy(1'b0); wait_busy(1'b1);
      @(negedge clk) hold = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 window stopped", busy, 0);
      d0 = disp;
      base = store_cnt;
      repeat (10) pulse_a(1, 2);
      repeat (70) @(negedge clk);
      chk("R10 no store in hold", store_cnt, base);
      chk("R10 display kept", disp, d0);
      @(negedge clk) hold = 1'b0;
      wait_busy(1'b1);
      repeat (3) pulse_a(1, 2);
      wait_store(base);
      chk("R10 fresh result", st_disp, 8'h03);
   endtask

   task automatic t_abort();
      int base;
      logic [7:0] d0;
      wait_busy(1'b0); wait_busy(1'b1);
      repeat (2) pulse_a(1, 2);
      d0 = disp;
      base = store_cnt;
      @(negedge clk) range_sel = 2'd1;
      repeat (30) @(negedge clk);
      chk("R9 no store on abort", store_cnt, base);
      chk("R9 display unchanged", disp, d0);
   endtask

   task automatic t_clr();
      @(negedge clk) clr_meas = 1'b1;
      @(negedge clk);
      chk("R12 clear disp", disp, 0);
      chk("R12 clear ovf", ovf, 0);
      chk("R12 clear busy", busy, 0);
      clr_meas = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_freq();
      t_osc();
      t_period();
      t_ratio();
      t_tint();
      t_unit();
      t_hold();
      t_abort();
      t_clr();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule